// File: doc/BRIEF.md
# Multiplexed Grid Sequencer with Master/Slave Sync

This block walks a multiplexed vacuum-fluorescent display through its grid time slots. On every slot strobe it moves to the next grid. It selects one of three segment latches to drive the segment outputs and pulls the matching active-low grid pre-driver line low. It also exports a 2-bit sync code and the dimming pulse, so that further devices can run in lock-step. A duty pin selects a two-grid or a three-grid cycle.

When the master pin is low, the device becomes a follower and its own slot counter has no effect on its outputs. The incoming 2-bit sync code picks the latch. The incoming dim pulse gates the segments. All grid lines stay inactive (high), and the exported sync code and dim pulse stay low. The oscillator that makes the slot strobe, the segment latches and the high-voltage pad drivers are outside this block.

All outputs are registered, so they follow their inputs one clock later. A slot strobe sampled on one edge shows up on the grid, sync and segment outputs one edge after that.

Top module: `vfd_grid_seq`

## Requirements
- R1: While reset is asserted, every segment output is low, grid_n_out is 3'b110 (first grid active, the other two inactive), and sync_out and dim_out are 0.
- R2: In master mode with duplex_sel high, each slot strobe alternates the active grid between grid 0 and grid 1. grid_n_out[2] stays high, and grid_n_out does not change without a strobe.
- R3: In master mode with duplex_sel low, each strobe steps the active grid 0, 1, 2, then back to 0.
- R4: Grid outputs are active low. At most one grid line is low at any time, and only during its own slot.
- R5: In master mode sync_out carries the slot code, with sync_out[0] as the first sync line and sync_out[1] as the second: slot 0 gives 2'b01, slot 1 gives 2'b10, slot 2 gives 2'b11.
- R6: In master mode seg_out equals the latch of the current slot ANDed with dim_en_local, and dim_out equals dim_en_local.
- R7: In master mode sync_in and dim_in have no effect on any output.
- R8: In slave mode sync_in code 1, 2 or 3 selects latch 0, 1 or 2 (latch k sits at latch_bits[k*SEG_W +: SEG_W]), and seg_out is that latch ANDed with dim_in.
- R9: In slave mode with sync_in equal to 2'b00, all segment outputs are low whatever dim_in is.
- R10: In slave mode grid_n_out is 3'b111, and sync_out and dim_out are 0.
- R11: A segment output is high only when the corresponding bit of the selected latch is 1.
- R12: If the slot counter sits on grid 2 when duplex_sel goes high, the next strobe returns it to grid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duplex_sel | input | 1 | 1: two-grid cycle, 0: three-grid cycle |
| master_sel | input | 1 | 1: master (own timing), 0: slave (follows sync/dim inputs) |
| slot_tick | input | 1 | One-cycle strobe that advances the grid slot |
| dim_en_local | input | 1 | Local dimming pulse used in master mode |
| dim_in | input | 1 | Dimming pulse from a master, used in slave mode |
| sync_in | input | 2 | Sync code from a master; bit 0 is the first line |
| latch_bits | input | 3*SEG_W | Three segment latches, latch k at [k*SEG_W +: SEG_W] |
| seg_out | output | SEG_W | Segment (anode) drive, high = lit |
| grid_n_out | output | 3 | Active-low grid pre-driver lines |
| sync_out | output | 2 | Exported slot code for slaves |
| dim_out | output | 1 | Exported dimming pulse for slaves |

## Verification
The bench steps the three-grid and two-grid cycles through their wrap points. A counter that wraps at the wrong value would light grid 2 during a duplex cycle or skip it in triplex. It switches from triplex to duplex while the counter sits on grid 2. A design that compares only for equality with the last slot would then run past the end instead of returning to grid 0. In slave mode it presents code 00 with the dim pulse high, and it drives each nonzero code. An off-by-one decode would light the wrong latch, or any latch at all for code 00. It also feeds junk on the sync and dim inputs in master mode, where a leaky mode mux would disturb the outputs.

// File: rtl/vfd_gseq_pkg.sv
package vfd_gseq_pkg;
  localparam int NUM_GRIDS = 3;
  localparam int SLOT_W    = 2;

  // slot index -> exported code (0 reserved for "no grid")
  function automatic logic [SLOT_W-1:0] code_of_slot(input logic [SLOT_W-1:0] s);
    return s + 2'd1;
  endfunction

  // final slot index of one display frame
  function automatic logic [SLOT_W-1:0] last_slot(input logic duplex);
    return duplex ? 2'd1 : 2'd2;
  endfunction

  // active-low grid lines for a slot index
  function automatic logic [NUM_GRIDS-1:0] grid_lines_n(input logic [SLOT_W-1:0] s);
    logic [NUM_GRIDS-1:0] g;
    g = '1;
    for (int i = 0; i < NUM_GRIDS; i++)
      if (s == SLOT_W'(i)) g[i] = 1'b0;
    return g;
  endfunction
endpackage

// File: rtl/vfd_slot_ctr.sv
module vfd_slot_ctr
  import vfd_gseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              duplex,
  output logic [SLOT_W-1:0] slot_q
);
  logic wrap_now;

  // >= also catches a slot left beyond the end by a duty change
  assign wrap_now = slot_q >= last_slot(duplex);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slot_q <= '0;
    else if (tick)
      slot_q <= wrap_now ? '0 : slot_q + 1'b1;
  end
endmodule

// File: rtl/vfd_seg_mux.sv
module vfd_seg_mux
  import vfd_gseq_pkg::*;
#(
  parameter int SEG_W = 56
) (
  input  logic [NUM_GRIDS*SEG_W-1:0] latch_bits,
  input  logic [SLOT_W-1:0]          pick_code,
  input  logic                       gate,
  output logic [SEG_W-1:0]           seg
);
  logic [NUM_GRIDS-1:0][SEG_W-1:0] lane;

  genvar g;
  generate
    for (g = 0; g < NUM_GRIDS; g++) begin : g_lane
      assign lane[g] = (pick_code == code_of_slot(SLOT_W'(g)))
                       ? latch_bits[g*SEG_W +: SEG_W] : '0;
    end
  endgenerate

  always_comb begin
    seg = '0;
    for (int i = 0; i < NUM_GRIDS; i++) seg |= lane[i];
    seg &= {SEG_W{gate}};
  end
endmodule

// File: rtl/vfd_grid_seq.sv
module vfd_grid_seq
  import vfd_gseq_pkg::*;
#(
  parameter int SEG_W = 56
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       duplex_sel,
  input  logic                       master_sel,
  input  logic                       slot_tick,
  input  logic                       dim_en_local,
  input  logic                       dim_in,
  input  logic [1:0]                 sync_in,
  input  logic [NUM_GRIDS*SEG_W-1:0] latch_bits,
  output logic [SEG_W-1:0]           seg_out,
  output logic [NUM_GRIDS-1:0]       grid_n_out,
  output logic [1:0]                 sync_out,
  output logic                       dim_out
);
  localparam logic [NUM_GRIDS-1:0] GRID_RST = grid_lines_n('0);

  logic [SLOT_W-1:0]    slot_q;
  logic [SLOT_W-1:0]    pick_code;
  logic                 seg_gate;
  logic [SEG_W-1:0]     seg_nxt;
  logic [NUM_GRIDS-1:0] grid_nxt;
  logic [1:0]           sync_nxt;
  logic                 dim_nxt;

  vfd_slot_ctr u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (slot_tick),
    .duplex (duplex_sel),
    .slot_q (slot_q)
  );

  // both modes share one code-space selector
  assign pick_code = master_sel ? code_of_slot(slot_q) : sync_in;
  assign seg_gate  = master_sel ? dim_en_local : dim_in;

  vfd_seg_mux #(.SEG_W(SEG_W)) u_mux (
    .latch_bits (latch_bits),
    .pick_code  (pick_code),
    .gate       (seg_gate),
    .seg        (seg_nxt)
  );

  assign grid_nxt = master_sel ? grid_lines_n(slot_q) : '1;
  assign sync_nxt = master_sel ? code_of_slot(slot_q) : 2'b00;
  assign dim_nxt  = master_sel & dim_en_local;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_out    <= '0;
      grid_n_out <= GRID_RST;
      sync_out   <= 2'b00;
      dim_out    <= 1'b0;
    end else begin
      seg_out    <= seg_nxt;
      grid_n_out <= grid_nxt;
      sync_out   <= sync_nxt;
      dim_out    <= dim_nxt;
    end
  end
endmodule

// File: rtl/vfd_grid_seq_chk.sv
module vfd_grid_seq_chk #(
  parameter int SEG_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_sel,
  input logic             slot_tick,
  input logic             dim_en_local,
  input logic [1:0]       sync_in,
  input logic [3*SEG_W-1:0] latch_bits,
  input logic [SEG_W-1:0] seg_out,
  input logic [2:0]       grid_n_out,
  input logic [1:0]       sync_out,
  input logic             dim_out,
  input logic [1:0]       slot_q
);
  logic [SEG_W-1:0] any_latch;
  assign any_latch = latch_bits[0 +: SEG_W] | latch_bits[SEG_W +: SEG_W]
                   | latch_bits[2*SEG_W +: SEG_W];

  // R2
  grid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(master_sel) && $past(master_sel, 2)
     && !$past(slot_tick, 2)) |-> $stable(grid_n_out));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != 2'd3);

  // R4
  one_grid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grid_n_out));

  // R5
  code_grid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(master_sel)) |->
      (sync_out != 2'b00) && (grid_n_out[0] == (sync_out != 2'd1))
      && (grid_n_out[1] == (sync_out != 2'd2)) && (grid_n_out[2] == (sync_out != 2'd3)));

  // R6
  master_dim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(master_sel) && !$past(dim_en_local)) |-> (seg_out == '0) && !dim_out);

  // R9
  slave_none_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(master_sel) && ($past(sync_in) == 2'b00)) |-> seg_out == '0);

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(master_sel)) |->
      (grid_n_out == 3'b111) && (sync_out == 2'b00) && !dim_out);

  // R11
  seg_from_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (seg_out & ~$past(any_latch)) == '0);
endmodule

bind vfd_grid_seq vfd_grid_seq_chk #(.SEG_W(SEG_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .master_sel   (master_sel),
  .slot_tick    (slot_tick),
  .dim_en_local (dim_en_local),
  .sync_in      (sync_in),
  .latch_bits   (latch_bits),
  .seg_out      (seg_out),
  .grid_n_out   (grid_n_out),
  .sync_out     (sync_out),
  .dim_out      (dim_out),
  .slot_q       (slot_q)
);

// File: tb/test_vfd_grid_seq.sv
module test_vfd_grid_seq;
  localparam int SEG_W = 56;
  localparam logic [SEG_W-1:0] L0 = 56'h123456789ABCDE;
  localparam logic [SEG_W-1:0] L1 = 56'hFEDCBA98765432;
  localparam logic [SEG_W-1:0] L2 = 56'h0F0F0F00F0F0F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic duplex_sel = 1'b0, master_sel = 1'b1, slot_tick = 1'b0;
  logic dim_en_local = 1'b1, dim_in = 1'b0;
  logic [1:0] sync_in = 2'b00;
  logic [3*SEG_W-1:0] latch_bits;
  logic [SEG_W-1:0] seg_out;
  logic [2:0] grid_n_out;
  logic [1:0] sync_out;
  logic dim_out;

  assign latch_bits = {L2, L1, L0};
  always #5 clk = ~clk;

  vfd_grid_seq #(.SEG_W(SEG_W)) i_vfd_grid_seq (
    .clk(clk), .rst_n(rst_n), .duplex_sel(duplex_sel), .master_sel(master_sel),
    .slot_tick(slot_tick), .dim_en_local(dim_en_local), .dim_in(dim_in),
    .sync_in(sync_in), .latch_bits(latch_bits), .seg_out(seg_out),
    .grid_n_out(grid_n_out), .sync_out(sync_out), .dim_out(dim_out)
  );

  typedef struct {
    logic [SEG_W-1:0] seg;
    logic [2:0]       grid;
    logic [1:0]       sync;
    logic             dim;
    string            tag;
  } exp_t;

  exp_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int model_slot = 0;

  task automatic compare(input exp_t e);
    n_cmp++;
    if (seg_out !== e.seg || grid_n_out !== e.grid || sync_out !== e.sync || dim_out !== e.dim) begin
      n_bad++;
      $display("FAIL %s: got seg=%h grid=%b sync=%b dim=%b, expected seg=%h grid=%b sync=%b dim=%b",
               e.tag, seg_out, grid_n_out, sync_out, dim_out, e.seg, e.grid, e.sync, e.dim);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) compare(sb_q.pop_front());
  end

  function automatic exp_t predict(input logic ms, den, din, input logic [1:0] sin, input string tag);
    exp_t e;
    e.tag = tag;
    if (ms) begin
      case (model_slot)
        0: begin e.seg = L0; e.grid = 3'b110; e.sync = 2'b01; end
        1: begin e.seg = L1; e.grid = 3'b101; e.sync = 2'b10; end
        default: begin e.seg = L2; e.grid = 3'b011; e.sync = 2'b11; end
      endcase
      if (!den) e.seg = '0;
      e.dim = den;
    end else begin
      case (sin)
        2'd1: e.seg = L0;
        2'd2: e.seg = L1;
        2'd3: e.seg = L2;
        default: e.seg = '0;
      endcase
      if (!din) e.seg = '0;
      e.grid = 3'b111; e.sync = 2'b00; e.dim = 1'b0;
    end
    return e;
  endfunction

  // driver: apply, hold through two edges, push expectation
  task automatic step(input logic ms, dup, den, din, input logic [1:0] sin,
                      input logic tick, input string tag);
    @(negedge clk);
    master_sel = ms; duplex_sel = dup; dim_en_local = den; dim_in = din;
    sync_in = sin; slot_tick = tick;
    @(posedge clk);
    if (tick) begin
      if (model_slot >= (dup ? 1 : 2)) model_slot = 0;
      else model_slot = model_slot + 1;
    end
    @(negedge clk);
    slot_tick = 1'b0;
    @(posedge clk);
    #1;
    sb_q.push_back(predict(ms, den, din, sin, tag));
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    begin
      exp_t r;
      r.seg = '0; r.grid = 3'b110; r.sync = 2'b00; r.dim = 1'b0; r.tag = "R1 reset";
      compare(r);
    end
    rst_n = 1'b1;

    step(1, 0, 1, 0, 2'b00, 0, "R6 R5 master slot0");
    step(1, 0, 1, 0, 2'b00, 1, "R3 triplex to grid1");
    step(1, 0, 1, 0, 2'b00, 1, "R3 triplex to grid2");
    step(1, 0, 1, 0, 2'b00, 1, "R3 triplex wrap to grid0");
    step(1, 0, 0, 0, 2'b00, 0, "R6 local dim off");
    step(1, 0, 1, 0, 2'b11, 0, "R7 master ignores sync_in");
    step(1, 0, 0, 1, 2'b10, 0, "R7 master ignores dim_in");
    step(1, 1, 1, 0, 2'b00, 1, "R2 duplex to grid1");
    step(1, 1, 1, 0, 2'b00, 1, "R2 duplex back to grid0");
    step(1, 1, 1, 0, 2'b00, 1, "R2 duplex grid1 again");
    step(1, 1, 1, 0, 2'b00, 1, "R2 R4 duplex grid0, grid2 idle");
    step(1, 1, 1, 0, 2'b00, 0, "R2 no strobe holds grid");
    step(1, 0, 1, 0, 2'b00, 1, "R3 triplex grid1");
    step(1, 0, 1, 0, 2'b00, 1, "R3 triplex grid2");
    step(1, 1, 1, 0, 2'b00, 0, "R12 duty change leaves grid2 until strobe");
    step(1, 1, 1, 0, 2'b00, 1, "R12 strobe from grid2 in duplex gives grid0");
    step(0, 0, 1, 1, 2'b00, 0, "R9 R10 slave code 00 dark");
    step(0, 0, 1, 1, 2'b01, 0, "R8 slave code 1 latch0");
    step(0, 0, 0, 1, 2'b10, 0, "R8 slave code 2 latch1");
    step(0, 0, 1, 1, 2'b11, 0, "R8 R11 slave code 3 latch2");
    step(0, 0, 1, 0, 2'b11, 0, "R8 slave dim_in low");
    step(0, 1, 1, 1, 2'b01, 1, "R10 slave strobe leaves grids idle");
    step(1, 1, 1, 0, 2'b00, 0, "R4 back to master follows counter");
    step(1, 1, 1, 0, 2'b00, 1, "R4 master strobe after slave");

    wait (sb_q.size() == 0);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule